// File: doc/BRIEF.md
# Shared-Slave Bus Arbiter with Default-Master Parking

This block decides which of up to sixteen bus masters owns a single shared slave port. Each master presents a request, a flag marking the start of a new non-sequential transfer, and the length of the transfer it is issuing. The slave reports every completed data beat. The block answers with a registered one-hot grant and the index of the connected master. Two selection algorithms are available: round-robin and fixed priority. The winner changes only on cycles where no burst is cut short.

When no master is requesting, a parking policy decides where the port rests. It can be left unconnected, which saves power. It can stay with the master that most recently won arbitration, or it can return to a master named by configuration. A master that is already parked on the port starts its next transfer without waiting for an arbitration cycle. Address decoding, data steering and register access sit outside this block.

Top module: `slave_arbiter`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `grant_o` is all zeros and `owner_vld_o` is 0.
- R2: With `arb_mode_i`=1 (fixed priority), an arbitration cycle with pending requests connects the lowest-numbered requesting master.
- R3: With `arb_mode_i`=0 (round-robin), an arbitration cycle with pending requests connects the first requesting master found by searching upward from the one after the last master granted through a request, wrapping at `N_MASTERS`. After reset the search starts at master 0.
- R4: Ownership decided on a cycle appears on the outputs after the next rising edge. `grant_o` is one-hot or zero, and bit k is set exactly when `owner_vld_o`=1 and `owner_o`=k.
- R5: A defined-length transfer is one whose `len_i` field is nonzero at its first beat, with the field giving the beat count. The connected master keeps the port until the beat that completes the count, even if other masters request.
- R6: A transfer of length 1 (a single access) allows re-arbitration on the cycle of its beat.
- R7: A transfer whose first beat has `len_i`=0 has undefined length. It keeps the port until its master drops its request or raises its `nonseq_i` bit, and either event allows re-arbitration on that cycle.
- R8: When the connected master is not requesting, or no master is connected, every cycle is an arbitration cycle.
- R9: With `dm_type_i`=0 and no requests on an arbitration cycle, the port disconnects, so `grant_o`=0.
- R10: With `dm_type_i`=1 and no requests on an arbitration cycle, the port connects to the last master granted through a request. It stays unconnected if no master has been granted yet.
- R11: With `dm_type_i`=2 and no requests on an arbitration cycle, the port connects to master `dm_fix_i`. `dm_type_i`=3 behaves as 0.
- R12: A `dm_fix_i` value of `N_MASTERS` or more is never granted. The port stays disconnected instead.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | N_MASTERS | Per-master access request |
| nonseq_i | input | N_MASTERS | Per-master start of a new non-sequential transfer |
| len_i | input | N_MASTERS*LEN_W | Per-master transfer length in beats, 0 = undefined; master k uses bits [k*LEN_W +: LEN_W] |
| beat_i | input | 1 | Slave completes a beat of the connected master this cycle |
| arb_mode_i | input | 1 | 0 = round-robin, 1 = fixed priority |
| dm_type_i | input | 2 | Parking policy: 0 none, 1 last granted, 2 fixed, 3 none |
| dm_fix_i | input | 4 | Master index used when parking is fixed |
| grant_o | output | N_MASTERS | One-hot grant to the connected master |
| owner_o | output | 4 | Index of the connected master |
| owner_vld_o | output | 1 | A master is connected |

## Verification
A wrong beat count shows up at the ports as a grant that moves in the middle of a burst or lingers after it ends. The error appears one edge after the miscounted beat. A stale round-robin pointer shows up as a wrong winner at the next contested arbitration. A wrong parking choice shows up on the first idle cycle. Because the port re-arbitrates on every idle cycle, a corrupted owner register is overwritten or exposed within one or two cycles of the requests stopping. The stimulus compares the grant against an independent cycle model on every clock, so each of these errors is reported within a cycle of showing at the ports.

// File: rtl/sarb_pkg.sv
`timescale 1ns/1ps
package sarb_pkg;

  localparam int MAX_M = 16;
  localparam int IDX_W = 4;

  typedef enum logic [1:0] {
    PARK_NONE  = 2'd0,
    PARK_LAST  = 2'd1,
    PARK_FIXED = 2'd2,
    PARK_RSVD  = 2'd3
  } park_e;

  // lowest set bit of a padded request vector
  function automatic logic [IDX_W-1:0] lowest_req(input logic [MAX_M-1:0] m);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = MAX_M - 1; i >= 0; i--) begin
      if (m[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  // first set bit found scanning upward from prev+1, wrapping at n
  function automatic logic [IDX_W-1:0] rotate_req(input logic [MAX_M-1:0] m,
                                                  input logic [IDX_W-1:0] prev,
                                                  input int n);
    logic [IDX_W-1:0] r;
    logic             hit;
    int               pos;
    r   = '0;
    hit = 1'b0;
    for (int s = 1; s <= MAX_M; s++) begin
      if (s <= n && !hit) begin
        pos = (int'(prev) + s) % n;
        if (m[pos[IDX_W-1:0]]) begin
          r   = pos[IDX_W-1:0];
          hit = 1'b1;
        end
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/sarb_burst_track.sv
`timescale 1ns/1ps
module sarb_burst_track #(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             own_req,
  input  logic             own_nonseq,
  input  logic [LEN_W-1:0] own_len,
  input  logic             beat,
  output logic             arb_ok,
  output logic             idle_cyc,
  output logic             last_beat,
  output logic             undef_end
);

  logic             in_xfer_q;
  logic             undef_q;
  logic [LEN_W-1:0] left_q;
  logic             cur_undef;
  logic [LEN_W-1:0] cur_left;

  always_comb begin
    cur_undef = in_xfer_q ? undef_q : (own_len == '0);
    cur_left  = in_xfer_q ? left_q  : own_len;
    idle_cyc  = !own_req;
    last_beat = own_req && beat && !cur_undef && (cur_left == LEN_W'(1));
    undef_end = own_req && in_xfer_q && undef_q && own_nonseq;
    arb_ok    = idle_cyc || last_beat || undef_end;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_xfer_q <= 1'b0;
      undef_q   <= 1'b0;
      left_q    <= '0;
    end else if (arb_ok) begin
      in_xfer_q <= 1'b0;
      undef_q   <= 1'b0;
      left_q    <= '0;
    end else if (beat) begin
      in_xfer_q <= 1'b1;
      undef_q   <= cur_undef;
      left_q    <= cur_undef ? '0 : cur_left - LEN_W'(1);
    end
  end

endmodule

// File: rtl/sarb_pick.sv
`timescale 1ns/1ps
module sarb_pick
  import sarb_pkg::*;
#(
  parameter int N_MASTERS = 4
) (
  input  logic [N_MASTERS-1:0] req,
  input  logic                 fixed_mode,
  input  logic [IDX_W-1:0]     prev_idx,
  output logic                 any_req,
  output logic [IDX_W-1:0]     win_idx
);

  logic [MAX_M-1:0] padded;

  always_comb begin
    padded = '0;
    padded[N_MASTERS-1:0] = req;
    any_req = |req;
    win_idx = fixed_mode ? lowest_req(padded)
                         : rotate_req(padded, prev_idx, N_MASTERS);
  end

endmodule

// File: rtl/sarb_park.sv
`timescale 1ns/1ps
module sarb_park
  import sarb_pkg::*;
#(
  parameter int N_MASTERS = 4
) (
  input  logic [1:0]       park_type,
  input  logic [IDX_W-1:0] fix_idx,
  input  logic [IDX_W-1:0] recent_idx,
  input  logic             recent_vld,
  output logic             park_vld,
  output logic [IDX_W-1:0] park_idx
);

  always_comb begin
    park_vld = 1'b0;
    park_idx = '0;
    case (park_e'(park_type))
      PARK_LAST: begin
        park_vld = recent_vld;
        park_idx = recent_idx;
      end
      PARK_FIXED: begin
        park_vld = (32'(fix_idx) < N_MASTERS);
        park_idx = park_vld ? fix_idx : '0;
      end
      default: begin
        park_vld = 1'b0;
        park_idx = '0;
      end
    endcase
  end

endmodule

// File: rtl/slave_arbiter.sv
`timescale 1ns/1ps
module slave_arbiter
  import sarb_pkg::*;
#(
  parameter int N_MASTERS = 4,
  parameter int LEN_W     = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_MASTERS-1:0]       req_i,
  input  logic [N_MASTERS-1:0]       nonseq_i,
  input  logic [N_MASTERS*LEN_W-1:0] len_i,
  input  logic                       beat_i,
  input  logic                       arb_mode_i,
  input  logic [1:0]                 dm_type_i,
  input  logic [IDX_W-1:0]           dm_fix_i,
  output logic [N_MASTERS-1:0]       grant_o,
  output logic [IDX_W-1:0]           owner_o,
  output logic                       owner_vld_o
);

  localparam logic [IDX_W-1:0] PTR_INIT = IDX_W'(N_MASTERS - 1);

  logic [IDX_W-1:0] owner_q;
  logic             owner_vld_q;
  logic [IDX_W-1:0] recent_q;
  logic             recent_vld_q;

  logic             own_req;
  logic             own_nonseq;
  logic [LEN_W-1:0] own_len;

  logic             arb_ok;
  logic             idle_cyc;
  logic             last_beat;
  logic             undef_end;
  logic             any_req;
  logic [IDX_W-1:0] win_idx;
  logic             park_vld;
  logic [IDX_W-1:0] park_idx;

  // inputs of the connected master
  always_comb begin
    own_req    = 1'b0;
    own_nonseq = 1'b0;
    own_len    = '0;
    for (int i = 0; i < N_MASTERS; i++) begin
      if (owner_vld_q && owner_q == IDX_W'(i)) begin
        own_req    = req_i[i];
        own_nonseq = nonseq_i[i];
        own_len    = len_i[i*LEN_W +: LEN_W];
      end
    end
  end

  sarb_burst_track #(.LEN_W(LEN_W)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .own_req   (own_req),
    .own_nonseq(own_nonseq),
    .own_len   (own_len),
    .beat      (beat_i),
    .arb_ok    (arb_ok),
    .idle_cyc  (idle_cyc),
    .last_beat (last_beat),
    .undef_end (undef_end)
  );

  sarb_pick #(.N_MASTERS(N_MASTERS)) u_pick (
    .req       (req_i),
    .fixed_mode(arb_mode_i),
    .prev_idx  (recent_q),
    .any_req   (any_req),
    .win_idx   (win_idx)
  );

  sarb_park #(.N_MASTERS(N_MASTERS)) u_park (
    .park_type (dm_type_i),
    .fix_idx   (dm_fix_i),
    .recent_idx(recent_q),
    .recent_vld(recent_vld_q),
    .park_vld  (park_vld),
    .park_idx  (park_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q      <= '0;
      owner_vld_q  <= 1'b0;
      recent_q     <= PTR_INIT;
      recent_vld_q <= 1'b0;
    end else if (arb_ok) begin
      if (any_req) begin
        owner_q      <= win_idx;
        owner_vld_q  <= 1'b1;
        recent_q     <= win_idx;
        recent_vld_q <= 1'b1;
      end else begin
        owner_q      <= park_idx;
        owner_vld_q  <= park_vld;
      end
    end
  end

  for (genvar g = 0; g < N_MASTERS; g++) begin : g_grant
    assign grant_o[g] = owner_vld_q && (owner_q == IDX_W'(g));
  end

  assign owner_o     = owner_q;
  assign owner_vld_o = owner_vld_q;

endmodule

// File: rtl/slave_arbiter_chk.sv
`timescale 1ns/1ps
module slave_arbiter_chk #(
  parameter int N_MASTERS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [N_MASTERS-1:0] req_i,
  input logic                 arb_mode_i,
  input logic [1:0]           dm_type_i,
  input logic [N_MASTERS-1:0] grant_o,
  input logic [3:0]           owner_o,
  input logic                 owner_vld_o,
  input logic                 arb_ok
);

  // R4
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  // R5
  hold_between_arb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !arb_ok |=> $stable(grant_o));

  // R2
  fixed_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_ok && arb_mode_i && req_i[0]) |=> grant_o[0]);

  // R9
  park_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_ok && req_i == '0 && (dm_type_i == 2'd0 || dm_type_i == 2'd3))
      |=> (grant_o == '0));

  // R12
  owner_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    owner_vld_o |-> (32'(owner_o) < N_MASTERS));

endmodule

bind slave_arbiter slave_arbiter_chk #(.N_MASTERS(N_MASTERS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_i      (req_i),
  .arb_mode_i (arb_mode_i),
  .dm_type_i  (dm_type_i),
  .grant_o    (grant_o),
  .owner_o    (owner_o),
  .owner_vld_o(owner_vld_o),
  .arb_ok     (arb_ok)
);

// File: tb/slave_arbiter_tb.sv
`timescale 1ns/1ps
module slave_arbiter_tb;

  localparam int N  = 4;
  localparam int LW = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    req = '0;
  logic [N-1:0]    nonseq = '0;
  logic [N*LW-1:0] len = '0;
  logic            beat = 1'b0;
  logic            mode = 1'b0;
  logic [1:0]      dmt = 2'd0;
  logic [3:0]      dfix = 4'd0;
  logic [N-1:0]    grant;
  logic [3:0]      owner;
  logic            owner_vld;

  int n_chk = 0;
  int n_fail = 0;

  // independent reference state
  int m_own = 0;
  bit m_vld = 0;
  int m_rem = 0;       // 0 idle, >0 beats left, -1 undefined burst
  int m_last = N - 1;
  bit m_lastv = 0;

  always #5 clk = ~clk;

  slave_arbiter #(.N_MASTERS(N), .LEN_W(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .nonseq_i(nonseq), .len_i(len),
    .beat_i(beat), .arb_mode_i(mode), .dm_type_i(dmt), .dm_fix_i(dfix),
    .grant_o(grant), .owner_o(owner), .owner_vld_o(owner_vld)
  );

  task automatic set_len(input int m, input int v);
    len[m*LW +: LW] = LW'(v);
  endtask

  task automatic judge(input bit ok, input string tag, input string act, input string exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %s expected %s", tag, act, exp);
    end
  endtask

  task automatic chk(input bit ev, input int ei, input string tag);
    logic [N-1:0] eg;
    eg = ev ? (N'(1) << ei) : '0;
    judge(owner_vld == ev && (!ev || int'(owner) == ei) && grant == eg, tag,
          $sformatf("vld=%0d own=%0d gnt=%b", owner_vld, owner, grant),
          $sformatf("vld=%0d own=%0d gnt=%b", ev, ei, eg));
  endtask

  // one clock: predict, step, compare, commit
  task automatic cyc(input string tag);
    int n_own, n_rem, n_last, L, w;
    bit n_vld, n_lastv, arb, oreq;
    n_own = m_own; n_vld = m_vld; n_rem = m_rem; n_last = m_last; n_lastv = m_lastv;
    arb = 1'b0; w = -1;
    oreq = m_vld && req[m_own];
    if (!oreq) arb = 1'b1;
    else if (m_rem < 0) arb = nonseq[m_own];
    else begin
      L = (m_rem > 0) ? m_rem : int'(len[m_own*LW +: LW]);
      if (L == 0) begin
        if (beat) n_rem = -1;
      end else if (beat && L == 1) arb = 1'b1;
      else if (beat) n_rem = L - 1;
    end
    if (arb) begin
      n_rem = 0;
      if (req != '0) begin
        if (mode) begin
          for (int k = N - 1; k >= 0; k--) if (req[k]) w = k;
        end else begin
          for (int s = N; s >= 1; s--) if (req[(m_last + s) % N]) w = (m_last + s) % N;
        end
        n_own = w; n_vld = 1; n_last = w; n_lastv = 1;
      end else if (dmt == 2'd1) begin
        n_vld = m_lastv; n_own = m_last;
      end else if (dmt == 2'd2) begin
        n_vld = (int'(dfix) < N); n_own = int'(dfix);
      end else n_vld = 0;
    end
    @(posedge clk); #1;
    chk(n_vld, n_own, tag);
    m_own = n_own; m_vld = n_vld; m_rem = n_rem; m_last = n_last; m_lastv = n_lastv;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    chk(0, 0, "R1 during reset");
    rst_n = 1'b1;
    for (int k = 0; k < N; k++) set_len(k, 1);
    chk(0, 0, "R1 after release");

    // fixed priority picks lowest
    mode = 1; dmt = 0; req = 4'b1010; beat = 0;
    cyc("R2 R4 first grant"); chk(1, 1, "R2 lowest requester");

    // defined burst of 3 beats is not broken
    set_len(1, 3); beat = 1; req = 4'b1011;
    cyc("R5 beat1"); chk(1, 1, "R5 hold after beat 1");
    cyc("R5 beat2"); chk(1, 1, "R5 hold after beat 2");
    cyc("R5 beat3"); chk(1, 0, "R5 R2 release at last beat");

    // round-robin over single accesses
    mode = 0; set_len(0, 1); set_len(1, 1);
    cyc("R6 single"); chk(1, 1, "R6 R3 rotate to 1");
    cyc("R3 rotate"); chk(1, 3, "R3 rotate to 3");
    cyc("R3 wrap");   chk(1, 0, "R3 wrap to 0");

    // undefined-length burst
    req = 4'b0011; set_len(0, 0); nonseq = '0;
    cyc("R7 start"); chk(1, 0, "R7 undefined start");
    cyc("R7 cont");  chk(1, 0, "R7 undefined held");
    nonseq = 4'b0001;
    cyc("R7 end");   chk(1, 1, "R7 nonseq ends burst");
    nonseq = '0;

    // owner drops request mid-burst
    set_len(1, 5);
    cyc("R5 long"); chk(1, 1, "R5 long burst held");
    req = 4'b0001;
    cyc("R8 idle"); chk(1, 0, "R8 idle owner rearbitrates");

    // parking policies
    req = '0; dmt = 2'd0;
    cyc("R9");  chk(0, 0, "R9 disconnect");
    dmt = 2'd1;
    cyc("R10"); chk(1, 0, "R10 park on last");
    dmt = 2'd2; dfix = 4'd2;
    cyc("R11"); chk(1, 2, "R11 park on fixed");
    dmt = 2'd3;
    cyc("R11 type3"); chk(0, 0, "R11 type 3 as none");
    dmt = 2'd2; dfix = 4'd9;
    cyc("R12"); chk(0, 0, "R12 out of range fixed");
    dfix = 4'd3;
    cyc("R11 again"); chk(1, 3, "R11 park on 3");

    // constrained random against the model
    for (int t = 0; t < 3000; t++) begin
      req    = ($urandom_range(0, 3) == 0) ? '0 : N'($urandom);
      nonseq = N'($urandom) & N'($urandom);
      for (int k = 0; k < N; k++) set_len(k, $urandom_range(0, 4));
      beat = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 31) == 0) begin
        mode = 1'($urandom);
        dmt  = 2'($urandom);
        dfix = 4'($urandom_range(0, 6));
      end
      cyc("R3 R5 R7 R10 random vs model");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule